// File: doc/BRIEF.md
# Base-Index Effective Address Generator

This block forms the effective address of a load or store. The address is the sum of three terms: a zero-extended displacement, an optional index register and a base register. The decoder reports the width of the displacement it extracted, which can be 12, 15, 16 or 20 bits. That width decides which group of integer registers the 3-bit base selector points into. With a 15-bit displacement the base is always one fixed register, whatever the selector holds.

The index selector picks one of integer registers 1 to 7, and a selector of 0 means the access has no index. When scaling is requested, the index is shifted left by log2 of the operand size before the add, so that it counts elements rather than bytes. A byte operand is never shifted.

The block drives the two register numbers for a read port of the integer register file and takes back the read data in the same cycle. It registers the 64-bit address together with a flag that marks an illegal base selector. The result appears one cycle after the request.

Top module: `bidx_agen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `bad_sel` and `eff_addr` are all zero.
- R2: A request with `in_valid` high produces its result on `eff_addr` and `bad_sel` one clock later, with `out_valid` high. If `in_valid` is low, `out_valid` is low one clock later and `eff_addr` and `bad_sel` keep their previous values.
- R3: The `disp_kind` encoding is 0 for 12-bit, 1 for 15-bit, 2 for 16-bit and 3 for 20-bit. For kind 0 with a nonzero `base_sel`, `base_rd_num` is 8 + `base_sel`, in the same cycle as the request.
- R4: For a nonzero `base_sel`, kind 2 drives `base_rd_num` = 24 + `base_sel` and kind 3 drives `base_rd_num` = 16 + `base_sel`.
- R5: For kind 1, `base_rd_num` is 24 for every value of `base_sel`, and the result never raises `bad_sel`.
- R6: For kinds 0, 2 and 3, a `base_sel` of 0 is illegal. `base_rd_num` is then 0, and the registered result has `bad_sel` = 1 and `eff_addr` = 0.
- R7: `index_rd_num` always equals `index_sel`. When `index_sel` is 0, the index term is zero whatever `index_rd_data` holds.
- R8: Only the low 12, 15, 16 or 20 bits of `disp` are used, according to the kind, and they are zero-extended. The bits of `disp` above that width have no effect on `eff_addr`.
- R9: The `op_size` encoding is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. With `scale_en` high, the index term is `index_rd_data` shifted left by `op_size`, which is no shift for a byte operand. With `scale_en` low, the index term is not shifted.
- R10: The three-term sum is taken modulo 2^64, and any carry out of bit 63 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| disp_kind | input | 2 | Displacement width code (0: 12, 1: 15, 2: 16, 3: 20 bits) |
| disp | input | 20 | Raw displacement bits, low-aligned |
| base_sel | input | 3 | Base selector within the group chosen by the width |
| index_sel | input | 3 | Index register number, 0 = no index |
| op_size | input | 2 | Operand size code (log2 of bytes) |
| scale_en | input | 1 | Scale the index by the operand size |
| base_rd_num | output | 5 | Register-file read number for the base |
| index_rd_num | output | 5 | Register-file read number for the index |
| base_rd_data | input | 64 | Base register read data, same cycle |
| index_rd_data | input | 64 | Index register read data, same cycle |
| out_valid | output | 1 | Registered result valid |
| eff_addr | output | 64 | Registered effective address |
| bad_sel | output | 1 | Registered illegal-base-selector flag |

## Verification
Two functions can fall in the same cycle: the illegal-selector check and the scaled-index add. In that cycle the flag has to win, and the output must not leak a partial sum. The bench provokes this by sending a zero base selector with a nonzero index, scaling enabled and an eight-byte operand. It then expects `bad_sel` set and an all-zero address. It also sends the 15-bit form with a zero selector and full scaling, and expects a clean sum built on register 24. Both cases are judged at the registered outputs one cycle after the request.

// File: rtl/bidx_agen_pkg.sv
package bidx_agen_pkg;

    localparam int XLEN   = 64;
    localparam int DISP_W = 20;
    localparam int RNUM_W = 5;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        DK_D12 = 2'd0,
        DK_D15 = 2'd1,
        DK_D16 = 2'd2,
        DK_D20 = 2'd3
    } disp_kind_e;

    typedef enum logic [1:0] {
        OS_BYTE   = 2'd0,
        OS_HALF   = 2'd1,
        OS_WORD   = 2'd2,
        OS_DOUBLE = 2'd3
    } op_size_e;

    // Register number just below the first member of each seven-entry group
    localparam logic [RNUM_W-1:0] GRP12_ORIGIN   = 5'd8;
    localparam logic [RNUM_W-1:0] GRP16_ORIGIN   = 5'd24;
    localparam logic [RNUM_W-1:0] GRP20_ORIGIN   = 5'd16;
    localparam logic [RNUM_W-1:0] FIXED15_REG    = 5'd24;

    typedef struct packed {
        logic [RNUM_W-1:0] base_num;
        logic [RNUM_W-1:0] index_num;
        logic              illegal;
        logic              index_used;
    } sel_map_t;

    function automatic int unsigned kind_width(disp_kind_e k);
        case (k)
            DK_D12:  return 12;
            DK_D15:  return 15;
            DK_D16:  return 16;
            default: return 20;
        endcase
    endfunction

    function automatic logic [RNUM_W-1:0] group_origin(disp_kind_e k);
        case (k)
            DK_D12:  return GRP12_ORIGIN;
            DK_D16:  return GRP16_ORIGIN;
            DK_D20:  return GRP20_ORIGIN;
            default: return FIXED15_REG;
        endcase
    endfunction

endpackage

// File: rtl/bidx_agen_regmap.sv
module bidx_agen_regmap
    import bidx_agen_pkg::*;
#(
    parameter int RN_W = RNUM_W,
    parameter int SL_W = SEL_W
) (
    input  disp_kind_e      kind,
    input  logic [SL_W-1:0] base_sel,
    input  logic [SL_W-1:0] index_sel,
    output sel_map_t        map
);
    localparam int PAD_W = RN_W - SL_W;

    logic             fixed_base;
    logic             zero_sel;
    logic [RN_W-1:0]  grouped;

    always_comb begin
        fixed_base = (kind == DK_D15);
        zero_sel   = (base_sel == '0);
        grouped    = group_origin(kind) + {{PAD_W{1'b0}}, base_sel};

        map.illegal    = !fixed_base && zero_sel;
        map.index_num  = {{PAD_W{1'b0}}, index_sel};
        map.index_used = (index_sel != '0);
        if (fixed_base)
            map.base_num = FIXED15_REG;
        else if (zero_sel)
            map.base_num = '0;
        else
            map.base_num = grouped;
    end
endmodule

// File: rtl/bidx_agen_scaler.sv
module bidx_agen_scaler
    import bidx_agen_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] idx_val,
    input  logic         used,
    input  logic         scale_en,
    input  op_size_e     size,
    output logic [W-1:0] idx_term
);
    localparam int N_SHIFTS = 4;

    logic [W-1:0] shifted [N_SHIFTS];

    for (genvar g = 0; g < N_SHIFTS; g++) begin : g_shift
        assign shifted[g] = idx_val << g;
    end

    always_comb begin
        if (!used)
            idx_term = '0;
        else if (!scale_en)
            idx_term = idx_val;
        else
            idx_term = shifted[size];
    end
endmodule

// File: rtl/bidx_agen_add3.sv
module bidx_agen_add3 #(
    parameter int W      = 64,
    parameter bit USE_CSA = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum
);
    if (USE_CSA) begin : g_csa
        logic [W-1:0] psum;
        logic [W-1:0] pcar;
        assign psum = a ^ b ^ c;
        assign pcar = (a & b) | (a & c) | (b & c);
        assign sum  = psum + {pcar[W-2:0], 1'b0};
    end else begin : g_ripple
        assign sum = a + b + c;
    end
endmodule

// File: rtl/bidx_agen.sv
module bidx_agen
    import bidx_agen_pkg::*;
#(
    parameter int ADDR_W  = XLEN,
    parameter int DW      = DISP_W,
    parameter bit USE_CSA = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        disp_kind,
    input  logic [DW-1:0]     disp,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [SEL_W-1:0]  index_sel,
    input  logic [1:0]        op_size,
    input  logic              scale_en,
    output logic [RNUM_W-1:0] base_rd_num,
    output logic [RNUM_W-1:0] index_rd_num,
    input  logic [ADDR_W-1:0] base_rd_data,
    input  logic [ADDR_W-1:0] index_rd_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              bad_sel
);
    localparam int EXT_W = ADDR_W - DW;

    disp_kind_e        kind;
    op_size_e          size;
    sel_map_t          map;
    logic [DW-1:0]     disp_keep;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] raw_sum;

    assign kind = disp_kind_e'(disp_kind);
    assign size = op_size_e'(op_size);

    bidx_agen_regmap u_map (
        .kind      (kind),
        .base_sel  (base_sel),
        .index_sel (index_sel),
        .map       (map)
    );

    assign base_rd_num  = map.base_num;
    assign index_rd_num = map.index_num;

    always_comb begin
        disp_keep = {DW{1'b1}} >> (DW - kind_width(kind));
        disp_ext  = {{EXT_W{1'b0}}, disp & disp_keep};
    end

    bidx_agen_scaler #(.W(ADDR_W)) u_scale (
        .idx_val  (index_rd_data),
        .used     (map.index_used),
        .scale_en (scale_en),
        .size     (size),
        .idx_term (idx_term)
    );

    bidx_agen_add3 #(.W(ADDR_W), .USE_CSA(USE_CSA)) u_add (
        .a   (base_rd_data),
        .b   (idx_term),
        .c   (disp_ext),
        .sum (raw_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            eff_addr  <= '0;
            bad_sel   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                eff_addr <= map.illegal ? '0 : raw_sum;
                bad_sel  <= map.illegal;
            end
        end
    end
endmodule

// File: rtl/bidx_agen_chk.sv
module bidx_agen_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [1:0] disp_kind,
    input logic [2:0] base_sel,
    input logic [2:0] index_sel,
    input logic [4:0] base_rd_num,
    input logic [4:0] index_rd_num,
    input logic       out_valid,
    input logic       bad_sel,
    input logic [63:0] eff_addr
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(eff_addr) && $stable(bad_sel));

    assert_grp12_range_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && disp_kind == 2'd0 && base_sel != 3'd0)
            |-> (base_rd_num >= 5'd9 && base_rd_num <= 5'd15));

    assert_grp16_range_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && disp_kind == 2'd2 && base_sel != 3'd0) |-> base_rd_num >= 5'd25);

    assert_fixed15_reg_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && disp_kind == 2'd1) |-> base_rd_num == 5'd24);

    assert_fixed15_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && disp_kind == 2'd1) |=> !bad_sel);

    assert_illegal_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && disp_kind != 2'd1 && base_sel == 3'd0) |=> bad_sel && eff_addr == 64'd0);

    assert_index_num_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> index_rd_num == {2'b00, index_sel});
endmodule

bind bidx_agen bidx_agen_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .disp_kind    (disp_kind),
    .base_sel     (base_sel),
    .index_sel    (index_sel),
    .base_rd_num  (base_rd_num),
    .index_rd_num (index_rd_num),
    .out_valid    (out_valid),
    .bad_sel      (bad_sel),
    .eff_addr     (eff_addr)
);

// File: tb/bidx_agen_tb_top.sv
module bidx_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  disp_kind;
    logic [19:0] disp;
    logic [2:0]  base_sel;
    logic [2:0]  index_sel;
    logic [1:0]  op_size;
    logic        scale_en;
    logic [4:0]  base_rd_num;
    logic [4:0]  index_rd_num;
    logic [63:0] base_rd_data;
    logic [63:0] index_rd_data;
    logic        out_valid;
    logic [63:0] eff_addr;
    logic        bad_sel;

    logic [63:0] rf [32];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign base_rd_data  = rf[base_rd_num];
    assign index_rd_data = rf[index_rd_num];

    bidx_agen dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .disp_kind(disp_kind),
        .disp(disp), .base_sel(base_sel), .index_sel(index_sel),
        .op_size(op_size), .scale_en(scale_en), .base_rd_num(base_rd_num),
        .index_rd_num(index_rd_num), .base_rd_data(base_rd_data),
        .index_rd_data(index_rd_data), .out_valid(out_valid),
        .eff_addr(eff_addr), .bad_sel(bad_sel)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_base(input logic [1:0] k, input logic [2:0] s);
        case (k)
            2'd0:    return (s == 0) ? 5'd0 : 5'd8  + {2'b0, s};
            2'd1:    return 5'd24;
            2'd2:    return (s == 0) ? 5'd0 : 5'd24 + {2'b0, s};
            default: return (s == 0) ? 5'd0 : 5'd16 + {2'b0, s};
        endcase
    endfunction

    function automatic logic [19:0] exp_disp(input logic [1:0] k, input logic [19:0] d);
        case (k)
            2'd0:    return d & 20'h00FFF;
            2'd1:    return d & 20'h07FFF;
            2'd2:    return d & 20'h0FFFF;
            default: return d;
        endcase
    endfunction

    // One request; checks read numbers in the request cycle and result one clock later
    task automatic do_req(input string req, input logic [1:0] k, input logic [19:0] d,
                          input logic [2:0] bs, input logic [2:0] is,
                          input logic [1:0] sz, input logic sc);
        logic [4:0]  bn;
        logic [63:0] idx;
        logic        bad;
        logic [63:0] exp_addr;
        @(negedge clk);
        in_valid = 1'b1; disp_kind = k; disp = d; base_sel = bs;
        index_sel = is; op_size = sz; scale_en = sc;
        bn  = exp_base(k, bs);
        bad = (k != 2'd1) && (bs == 0);
        idx = (is == 0) ? 64'd0 : rf[is];
        if (sc) idx = idx << sz;
        exp_addr = bad ? 64'd0 : rf[bn] + idx + {44'd0, exp_disp(k, d)};
        #1;
        check({req, " base_rd_num"}, {59'd0, base_rd_num}, {59'd0, bn});
        check({req, " index_rd_num"}, {59'd0, index_rd_num}, {59'd0, 2'b0, is});
        @(posedge clk); #1;
        check({req, " out_valid"}, {63'd0, out_valid}, 64'd1);
        check({req, " bad_sel"}, {63'd0, bad_sel}, {63'd0, bad});
        check({req, " eff_addr"}, eff_addr, exp_addr);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; disp_kind = 0; disp = 0;
        base_sel = 0; index_sel = 0; op_size = 0; scale_en = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 bad_sel", {63'd0, bad_sel}, 64'd0);
        check("R1 eff_addr", eff_addr, 64'd0);
    endtask

    task automatic t_groups;
        for (int s = 1; s < 8; s++) begin
            do_req("R3 grp12", 2'd0, 20'h00ABC, 3'(s), 3'd0, 2'd0, 1'b0);
            do_req("R4 grp16", 2'd2, 20'h01234, 3'(s), 3'd0, 2'd0, 1'b0);
            do_req("R4 grp20", 2'd3, 20'hFEDCB, 3'(s), 3'd0, 2'd0, 1'b0);
        end
    endtask

    task automatic t_fixed15;
        for (int s = 0; s < 8; s++)
            do_req("R5 fixed15", 2'd1, 20'h05555, 3'(s), 3'd2, 2'd1, 1'b1);
    endtask

    task automatic t_illegal;
        do_req("R6 illegal grp12", 2'd0, 20'h00111, 3'd0, 3'd5, 2'd3, 1'b1);
        do_req("R6 illegal grp16", 2'd2, 20'h0FFFF, 3'd0, 3'd7, 2'd2, 1'b1);
        do_req("R6 illegal grp20", 2'd3, 20'h80000, 3'd0, 3'd0, 2'd0, 1'b0);
        do_req("R6 recovers", 2'd2, 20'h00010, 3'd3, 3'd1, 2'd0, 1'b0);
    endtask

    task automatic t_index;
        do_req("R7 no index", 2'd2, 20'h00100, 3'd2, 3'd0, 2'd3, 1'b1);
        for (int i = 1; i < 8; i++)
            do_req("R7 index", 2'd0, 20'h00004, 3'd1, 3'(i), 2'd0, 1'b0);
    endtask

    task automatic t_disp_mask;
        do_req("R8 mask12", 2'd0, 20'hFF123, 3'd4, 3'd0, 2'd0, 1'b0);
        do_req("R8 mask15", 2'd1, 20'hFFFFF, 3'd0, 3'd0, 2'd0, 1'b0);
        do_req("R8 mask16", 2'd2, 20'hF8001, 3'd6, 3'd0, 2'd0, 1'b0);
        do_req("R8 full20", 2'd3, 20'hFFFFF, 3'd7, 3'd0, 2'd0, 1'b0);
    endtask

    task automatic t_scale;
        for (int z = 0; z < 4; z++) begin
            do_req("R9 scaled", 2'd2, 20'h00020, 3'd1, 3'd3, 2'(z), 1'b1);
            do_req("R9 unscaled", 2'd2, 20'h00020, 3'd1, 3'd3, 2'(z), 1'b0);
        end
    endtask

    task automatic t_wrap;
        do_req("R10 wrap", 2'd2, 20'h00020, 3'd7, 3'd6, 2'd3, 1'b1);
    endtask

    task automatic t_idle;
        logic [63:0] held;
        do_req("R2 load", 2'd3, 20'h12345, 3'd2, 3'd4, 2'd1, 1'b1);
        held = eff_addr;
        @(negedge clk);
        in_valid = 1'b0; base_sel = 3'd0; disp_kind = 2'd0; disp = 20'h00999;
        @(posedge clk); #1;
        check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle eff_addr held", eff_addr, held);
        check("R2 idle bad_sel held", {63'd0, bad_sel}, 64'd0);
        @(posedge clk); #1;
        check("R2 idle second cycle", eff_addr, held);
    endtask

    initial begin
        for (int r = 0; r < 32; r++)
            rf[r] = 64'h0001_0203_0000_0000 * 64'(r + 1) + 64'(r * 37 + 5);
        rf[31] = 64'hFFFF_FFFF_FFFF_FF00;
        rf[6]  = 64'h1000_0000_0000_0001;
        t_reset();
        t_groups();
        t_fixed15();
        t_illegal();
        t_index();
        t_disp_mask();
        t_scale();
        t_wrap();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule